// File: doc/BRIEF.md
# Serial Result Readout, Internal-Clock Master

This block moves a latched conversion word off chip over three wires and makes its own data clock to do so. At the start of each frame it copies the result word into a shift register. It then sends the word out most significant bit first. Each bit is framed by one pulse of a data clock derived from the system clock. A frame-sync output marks the whole time that the serial data line carries valid bits.

A host enables the port by holding both its select and read strobes low. A read-mode input picks when a frame begins:
- In read-during-conversion mode, a frame starts when the busy flag rises. It sends the result that was held before the new conversion began.
- In read-after-conversion mode, a frame starts when busy falls, so the fresh result goes out.

Two polarity inputs set the active level of frame-sync and invert the data clock. Releasing either strobe in the middle of a frame abandons that frame at once.

Top module: `result_serial_master`

## Requirements
- R1: A frame carries the word present on `result_i` at the clock edge that starts the frame, sent most significant bit first, one bit per data-clock period. The word is not affected by later changes of `result_i`.
- R2: `sdout_o` changes only at the start of a bit period, while the data clock is in its inactive half. It holds its value across both clock edges of that bit. Between frames it is 0.
- R3: With `rd_during_i` = 1, the clock edge that first sees `busy_i` high after it was low starts a frame. The frame sends the value on `result_i` at that edge.
- R4: With `rd_during_i` = 0, the clock edge that first sees `busy_i` low after it was high starts a frame.
- R5: `sync_o` is at its active level for exactly 32*HALF_DIV system cycles per complete frame. The active level is high when `sync_low_i` = 0 and low when `sync_low_i` = 1. Otherwise it is at the opposite level.
- R6: Each bit period lasts 2*HALF_DIV cycles. Its first HALF_DIV cycles have the data clock inactive and its last HALF_DIV cycles have it active, which gives exactly 16 pulses per frame. Between frames `sclk_o` rests at the inactive level. The inactive level is 0 when `sclk_inv_i` = 0 and 1 when it is 1.
- R7: A frame starts only while `cs_n_i` and `rd_n_i` are both 0. If either strobe goes to 1 during a frame, the next cycle shows the idle state: sync inactive, clock at rest, data 0. No frame resumes when the strobes are lowered again.
- R8: During and right after reset, all three outputs are idle.
- R9: A busy edge that occurs while a frame is running is ignored. The running frame completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| result_i | input | 16 | Latched conversion result |
| busy_i | input | 1 | Conversion in progress flag |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| rd_during_i | input | 1 | 1: read during conversion, 0: read after conversion |
| sync_low_i | input | 1 | 1: frame-sync active low |
| sclk_inv_i | input | 1 | 1: invert data clock |
| sclk_o | output | 1 | Generated data clock |
| sync_o | output | 1 | Frame sync |
| sdout_o | output | 1 | Serial data, MSB first |

## Verification
The assertions check on every cycle these properties:
- A running frame stays alive while the strobes are held.
- Dropping a strobe ends the frame on the next cycle.
- Every frame begins at bit zero and count zero.
- A start request never repeats on consecutive cycles.
- Serial data does not move inside a bit period.

Only the bench scenarios can show that the right word goes out in the right order, and that each read mode reacts to the correct busy edge. They also show that the polarity selects act on the pins, that a frame blocked or cut short by the strobes leaves the pins idle, and that busy edges in mid-frame are ignored. The bench compares all three outputs against its cycle model on every cycle.

// File: rtl/srm_pkg.sv
package srm_pkg;
    typedef enum logic {
        RD_AFTER  = 1'b0,
        RD_DURING = 1'b1
    } rd_mode_e;

    function automatic logic busy_edge_hit(rd_mode_e mode, logic now, logic prev);
        return (mode == RD_DURING) ? (now && !prev) : (!now && prev);
    endfunction
endpackage

// File: rtl/srm_trigger.sv
module srm_trigger
    import srm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic mode_i,
    input  logic en_i,
    input  logic active_i,
    output logic start_o
);
    typedef struct packed {
        logic busy;
    } trig_t;

    trig_t d, q;

    always_comb begin
        d      = q;
        d.busy = busy_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start_o = en_i && !active_i &&
                     busy_edge_hit(rd_mode_e'(mode_i), busy_i, q.busy);

    // R9: a start is followed by a running frame, never a second start
    p_one_shot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
endmodule

// File: rtl/srm_timer.sv
module srm_timer #(
    parameter int DATA_W   = 16,
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic en_i,
    output logic active_o,
    output logic sclk_raw_o,
    output logic shift_o,
    output logic mid_bit_o
);
    localparam int BIT_CYC = 2 * HALF_DIV;
    localparam int CNT_W   = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
    localparam int BIT_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIT_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF_DIV);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bit_idx;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (q.active) begin
            if (!en_i) begin
                d.active = 1'b0;
            end else if (q.cnt == CNT_LAST) begin
                d.cnt = '0;
                if (q.bit_idx == BIT_LAST) d.active  = 1'b0;
                else                       d.bit_idx = q.bit_idx + 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (start_i) begin
            d.active  = 1'b1;
            d.cnt     = '0;
            d.bit_idx = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active_o   = q.active;
    assign sclk_raw_o = q.active && (q.cnt >= CNT_HALF);
    assign shift_o    = q.active && en_i && (q.cnt == CNT_LAST);
    assign mid_bit_o  = q.active && (q.cnt != '0);

    // R5 / R9: a held frame keeps running until its final count
    p_stay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && en_i && !(q.cnt == CNT_LAST && q.bit_idx == BIT_LAST))
        |=> q.active);

    // R7: strobe release ends the frame on the next edge
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !en_i) |=> !q.active);

    // R6: every frame opens at the first half of bit zero
    p_clean_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.active) |-> (q.cnt == '0 && q.bit_idx == '0));
endmodule

// File: rtl/srm_shifter.sv
module srm_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic              active_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              bit_o
);
    typedef struct packed {
        logic [DATA_W-1:0] sh;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d = q;
        if (load_i)       d.sh = word_i;
        else if (shift_i) d.sh = {q.sh[DATA_W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bit_o = active_i && q.sh[DATA_W-1];

    // R1: the register is loaded only between frames
    p_load_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !active_i);
endmodule

// File: rtl/result_serial_master.sv
module result_serial_master #(
    parameter int DATA_W   = 16,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] result_i,
    input  logic              busy_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              rd_during_i,
    input  logic              sync_low_i,
    input  logic              sclk_inv_i,
    output logic              sclk_o,
    output logic              sync_o,
    output logic              sdout_o
);
    logic en, start, active, sclk_raw, shift, mid_bit;

    assign en = !cs_n_i && !rd_n_i;

    srm_trigger u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (busy_i),
        .mode_i  (rd_during_i),
        .en_i    (en),
        .active_i(active),
        .start_o (start)
    );

    srm_timer #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .en_i      (en),
        .active_o  (active),
        .sclk_raw_o(sclk_raw),
        .shift_o   (shift),
        .mid_bit_o (mid_bit)
    );

    srm_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start),
        .shift_i (shift),
        .active_i(active),
        .word_i  (result_i),
        .bit_o   (sdout_o)
    );

    assign sclk_o = sclk_raw ^ sclk_inv_i;
    assign sync_o = active ^ sync_low_i;

    // R2: data holds for the whole bit period
    p_sdo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_bit && $past(active)) |-> $stable(sdout_o));
endmodule

// File: tb/result_serial_master_test.sv
module result_serial_master_test;
    localparam int W = 16;
    localparam int H = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] result = '0;
    logic busy = 1'b0, cs_n = 1'b1, rd_n = 1'b1;
    logic rdc = 1'b0, sinv = 1'b0, cinv = 1'b0;
    logic sclk, sync, sdout;

    always #5 clk = ~clk;

    result_serial_master #(.DATA_W(W), .HALF_DIV(H)) uut (
        .clk(clk), .rst_n(rst_n), .result_i(result), .busy_i(busy),
        .cs_n_i(cs_n), .rd_n_i(rd_n), .rd_during_i(rdc),
        .sync_low_i(sinv), .sclk_inv_i(cinv),
        .sclk_o(sclk), .sync_o(sync), .sdout_o(sdout)
    );

    int checks = 0;
    int errors = 0;
    string tag = "R8";

    // behavioural reference: frame position counted in system cycles
    bit       m_act = 0;
    int       m_k = 0;
    logic [W-1:0] m_word = '0;
    logic     m_prev = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_k = 0; m_prev = 0;
        end else begin
            bit en_now;
            bit edge_hit;
            en_now   = !cs_n && !rd_n;
            edge_hit = rdc ? (busy && !m_prev) : (!busy && m_prev);
            if (m_act) begin
                if (!en_now) m_act = 0;
                else begin
                    m_k++;
                    if (m_k == 32 * H) m_act = 0;
                end
            end else if (en_now && edge_hit) begin
                m_act = 1; m_k = 0; m_word = result;
            end
            m_prev = busy;
        end
    end

    always @(negedge clk) begin
        logic e_sync, e_sclk, e_sd;
        e_sync = m_act ^ sinv;
        e_sclk = (m_act && ((m_k % (2 * H)) >= H)) ^ cinv;
        e_sd   = m_act ? m_word[W - 1 - m_k / (2 * H)] : 1'b0;
        checks += 3;
        if (sync !== e_sync) begin
            errors++;
            $display("FAIL R5 %s sync act=%b exp=%b t=%0t", tag, sync, e_sync, $time);
        end
        if (sclk !== e_sclk) begin
            errors++;
            $display("FAIL R6 %s sclk act=%b exp=%b t=%0t", tag, sclk, e_sclk, $time);
        end
        if (sdout !== e_sd) begin
            errors++;
            $display("FAIL R1 R2 %s sdout act=%b exp=%b t=%0t", tag, sdout, e_sd, $time);
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic conv(int len);
        busy = 1'b1; tick(len);
        busy = 1'b0; tick(1);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1; tick(2);
        cs_n = 1'b0; rd_n = 1'b0;

        tag = "R4"; rdc = 1'b0;
        result = 16'hA5C3; conv(6); tick(80);
        tag = "R1";
        result = 16'h8001; conv(5); tick(80);
        result = 16'hFFFF; conv(5); tick(80);
        result = 16'h0000; conv(5); tick(80);

        tag = "R3"; rdc = 1'b1;
        result = 16'h1234; busy = 1'b1; tick(3);
        result = 16'h5678; tick(3); busy = 1'b0; tick(80);

        tag = "R5"; sinv = 1'b1;
        result = 16'h3C5A; conv(4); tick(80);
        tag = "R6"; sinv = 1'b0; cinv = 1'b1;
        result = 16'hC0DE; conv(4); tick(80);
        cinv = 1'b0;

        tag = "R7"; cs_n = 1'b1;
        result = 16'hBEEF; conv(4); tick(80);
        cs_n = 1'b0;
        result = 16'h7E81; busy = 1'b1; tick(20);
        rd_n = 1'b1; tick(10);
        rd_n = 1'b0; tick(40);
        busy = 1'b0; tick(80);

        tag = "R9";
        result = 16'h9669; busy = 1'b1; tick(10);
        busy = 1'b0; tick(5);
        result = 16'h0F0F; busy = 1'b1; tick(10);
        busy = 1'b0; tick(80);

        tag = "R8"; rst_n = 1'b0;
        result = 16'hFFFF; busy = 1'b1; tick(3);
        rst_n = 1'b1; tick(20);
        busy = 1'b0; tick(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule